// File: doc/BRIEF.md
# Component Video Test Pattern Sample Engine

This block computes the sample values of a 4:2:2 component digital video test signal from the current raster position. An external timing generator supplies a luma sample strobe, a zero-based horizontal luma sample index and a zero-based line index, both counted from the first active sample and line. The block returns one registered luma word per strobe. On every second luma sample it also returns a Cb word and a Cr word, which are co-sited with the odd-numbered luma samples when samples are counted from 1. Each stream carries its own qualifying strobe.

A three-bit select picks one of several patterns. The extended ramp runs past black and white so that clipping shows. The limit ramp spans the full legal code range. The shallow ramp is a slow staircase that exposes rounding and truncation. Digital gray is a flat field whose codes make the parallel data lines toggle. The co-siting pulse is a single peak sample that lines up luma against colour difference. A new select value is taken only at the start of a line. An 8-bit mode clears the two low bits of every word. Blanking intervals, timing reference codes and serialization are handled by other blocks.

Top module: `cvid_pattern_gen`

## Requirements
- R1: Every output is registered once: a sample presented with `pix_en` high appears on `y_data` with `y_stb` high on the next cycle. `c_stb` goes high, and `cb_data`/`cr_data` update, only for samples whose `h_pos` is even (odd-numbered when counting from 1). Otherwise the chroma words hold their previous value.
- R2: When `h_pos` >= 720 or `v_pos` >= V_ACTIVE (default 486), luma is 64 and both colour-difference words are 512, whatever the pattern.
- R3: Select code 0 (extended ramp) gives luma = 20 + floor(h_pos*1373/1024), which runs from 20 at h_pos 0 to 984 at h_pos 719. Chroma is 512.
- R4: Select code 1 (limit ramp) gives luma = 4 + floor(h_pos*1442/1024), which runs from 4 to 1016. Chroma is 512.
- R5: Select code 2 (shallow ramp) gives luma = 448 + floor(h_pos/8). Chroma is 512.
- R6: Select code 3 (digital gray) gives luma 508 and chroma 512 on every active sample.
- R7: Select code 4 (co-siting pulse) gives luma 940 at h_pos 360 (sample 361 counting from 1) and 64 elsewhere. Cb and Cr are 960 on that same sample and 512 elsewhere.
- R8: Select codes 5, 6 and 7 give flat black: luma 64, chroma 512.
- R9: `pat_sel` is taken when `pix_en` is high and `h_pos` is 0, and it applies from that sample on. Changes at any other time have no effect until the next such sample.
- R10: When `mode_8bit` is high, bits [1:0] of every word written with that sample are 0. The upper bits are the same as in 10-bit mode.
- R11: After reset, luma is 64, chroma is 512, both strobes are low, and the active select is code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Luma sample strobe for the current position |
| h_pos | input | H_W | Luma sample index from the start of active line |
| v_pos | input | V_W | Line index from the first active line |
| pat_sel | input | 3 | Pattern select code |
| mode_8bit | input | 1 | Clear the two low bits of every word |
| y_data | output | 10 | Luma sample |
| y_stb | output | 1 | Luma sample valid |
| cb_data | output | 10 | Blue colour-difference sample |
| cr_data | output | 10 | Red colour-difference sample |
| c_stb | output | 1 | Colour-difference samples valid |

## Verification
The bench targets the ramp end points 0 and 719. A slope constant rounded the wrong way would end at 983 or 1015 instead of 984 or 1016. It also checks that chroma is sampled and held on the correct parity of `h_pos`: a design that swapped parity would shift the co-siting pulse by one luma sample and would raise `c_stb` on odd positions. It changes the select in mid-line and while `pix_en` is low, where a design that latched too early would switch pattern mid-line. Finally it checks the first blanking samples and the low-bit masking, where an early or late active-window edge or a missed mask shows up as a wrong code.

// File: rtl/cvid_pattern_gen.sv
module cvid_pattern_gen #(
  parameter int H_W          = 11,
  parameter int V_W          = 10,
  parameter int H_ACTIVE     = 720,
  parameter int V_ACTIVE     = 486,
  parameter int SHALLOW_LOG2 = 3,
  parameter int SHALLOW_BASE = 448,
  parameter int COSITE_H     = 360
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_en,
  input  logic [H_W-1:0] h_pos,
  input  logic [V_W-1:0] v_pos,
  input  logic [2:0]     pat_sel,
  input  logic           mode_8bit,
  output logic [9:0]     y_data,
  output logic           y_stb,
  output logic [9:0]     cb_data,
  output logic [9:0]     cr_data,
  output logic           c_stb
);

  localparam int Y_BLACK    = 64;
  localparam int Y_WHITE    = 940;
  localparam int C_ZERO     = 512;
  localparam int C_PEAK     = 960;
  localparam int EXT_MARGIN = ((Y_WHITE - Y_BLACK) * 5 + 50) / 100;
  localparam int EXT_LO     = Y_BLACK - EXT_MARGIN;
  localparam int EXT_HI     = Y_WHITE + EXT_MARGIN;
  localparam int LIM_LO     = 4;
  localparam int LIM_HI     = 1016;
  localparam int FRAC       = 10;
  localparam int EXT_SLOPE  = (((EXT_HI - EXT_LO) << FRAC) + H_ACTIVE - 2) / (H_ACTIVE - 1);
  localparam int LIM_SLOPE  = (((LIM_HI - LIM_LO) << FRAC) + H_ACTIVE - 2) / (H_ACTIVE - 1);
  localparam int PW         = H_W + 12;

  localparam logic [2:0] PAT_EXT     = 3'd0;
  localparam logic [2:0] PAT_LIMIT   = 3'd1;
  localparam logic [2:0] PAT_SHALLOW = 3'd2;
  localparam logic [2:0] PAT_GRAY    = 3'd3;
  localparam logic [2:0] PAT_COSITE  = 3'd4;

  localparam logic [H_W-1:0] H_LIM  = H_W'(H_ACTIVE);
  localparam logic [V_W-1:0] V_LIM  = V_W'(V_ACTIVE);
  localparam logic [H_W-1:0] H_PULS = H_W'(COSITE_H);

  logic [2:0]    pat_q;
  logic [2:0]    pat_now;
  logic          line_start;
  logic          active;
  logic          cosite;
  logic [PW-1:0] ext_prod;
  logic [PW-1:0] lim_prod;
  logic [9:0]    y_n, c_n, y_m, c_m;

  assign line_start = pix_en && (h_pos == '0);
  assign pat_now    = line_start ? pat_sel : pat_q;
  assign active     = (h_pos < H_LIM) && (v_pos < V_LIM);
  assign cosite     = !h_pos[0];
  assign ext_prod   = PW'(h_pos) * PW'(EXT_SLOPE);
  assign lim_prod   = PW'(h_pos) * PW'(LIM_SLOPE);

  always_comb begin
    y_n = 10'(Y_BLACK);
    c_n = 10'(C_ZERO);
    if (active) begin
      case (pat_now)
        PAT_EXT:     y_n = 10'(EXT_LO) + 10'(ext_prod >> FRAC);
        PAT_LIMIT:   y_n = 10'(LIM_LO) + 10'(lim_prod >> FRAC);
        PAT_SHALLOW: y_n = 10'(SHALLOW_BASE) + 10'(h_pos >> SHALLOW_LOG2);
        PAT_GRAY:    y_n = 10'd508;
        PAT_COSITE:  if (h_pos == H_PULS) begin
                       y_n = 10'(Y_WHITE);
                       c_n = 10'(C_PEAK);
                     end
        default:     y_n = 10'(Y_BLACK);
      endcase
    end
  end

  assign y_m = mode_8bit ? {y_n[9:2], 2'b00} : y_n;
  assign c_m = mode_8bit ? {c_n[9:2], 2'b00} : c_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q   <= PAT_EXT;
      y_data  <= 10'(Y_BLACK);
      cb_data <= 10'(C_ZERO);
      cr_data <= 10'(C_ZERO);
      y_stb   <= 1'b0;
      c_stb   <= 1'b0;
    end else begin
      y_stb <= pix_en;
      c_stb <= pix_en && cosite;
      if (line_start) pat_q <= pat_sel;
      if (pix_en) y_data <= y_m;
      if (pix_en && cosite) begin
        cb_data <= c_m;
        cr_data <= c_m;
      end
    end
  end

  // R1
  c_within_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_stb |-> y_stb);

  // R1
  odd_no_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && h_pos[0]) |=> !c_stb);

  // R2
  blank_luma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !active) |=> (y_data == 10'd64));

  // R4
  limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && active && pat_now == PAT_LIMIT) |=> (y_data >= 10'd4 && y_data <= 10'd1016));

  // R10
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && mode_8bit) |=> (y_data[1:0] == 2'b00));

endmodule

// File: tb/cvid_pattern_gen_tb.sv
module cvid_pattern_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H_TOTAL    = 858;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic [10:0] h_pos = '0;
  logic [9:0]  v_pos = '0;
  logic [2:0]  pat_sel = '0;
  logic        mode_8bit = 1'b0;
  logic [9:0]  y_data, cb_data, cr_data;
  logic        y_stb, c_stb;

  int n_chk = 0;
  int n_bad = 0;
  int last_c = 512;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvid_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_pos(h_pos), .v_pos(v_pos),
    .pat_sel(pat_sel), .mode_8bit(mode_8bit), .y_data(y_data), .y_stb(y_stb),
    .cb_data(cb_data), .cr_data(cr_data), .c_stb(c_stb)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int msk(int v, bit m8);
    return m8 ? (v & ~3) : v;
  endfunction

  function automatic int ref_y(int pat, int h, int v, bit m8);
    int r;
    if (h >= 720 || v >= 486) r = 64;
    else case (pat)
      0: r = 20 + ((h * 1373) >> 10);
      1: r = 4 + ((h * 1442) >> 10);
      2: r = 448 + (h >> 3);
      3: r = 508;
      4: r = (h == 360) ? 940 : 64;
      default: r = 64;
    endcase
    return msk(r, m8);
  endfunction

  function automatic int ref_c(int pat, int h, int v, bit m8);
    int r = 512;
    if (h < 720 && v < 486 && pat == 4 && h == 360) r = 960;
    return msk(r, m8);
  endfunction

  task automatic step(int h, int v, int pat, bit m8, bit en);
    h_pos = 11'(h); v_pos = 10'(v); pat_sel = 3'(pat); mode_8bit = m8; pix_en = en;
    @(posedge clk); #1;
  endtask

  task automatic sample(string tag, int h, int v, int pat, int exp_pat, bit m8);
    step(h, v, pat, m8, 1'b1);
    chk(tag, "y_stb", int'(y_stb), 1);
    chk(tag, "y_data", int'(y_data), ref_y(exp_pat, h, v, m8));
    if (h % 2 == 0) begin
      last_c = ref_c(exp_pat, h, v, m8);
      chk(tag, "c_stb", int'(c_stb), 1);
    end else begin
      chk(tag, "c_stb", int'(c_stb), 0);
    end
    chk(tag, "cb_data", int'(cb_data), last_c);
    chk(tag, "cr_data", int'(cr_data), last_c);
  endtask

  task automatic run_line(string tag, int pat, int v, bit m8);
    for (int h = 0; h < H_TOTAL; h++) sample(tag, h, v, pat, pat, m8);
  endtask

  task automatic t_reset();
    chk("R11", "y_data", int'(y_data), 64);
    chk("R11", "cb_data", int'(cb_data), 512);
    chk("R11", "cr_data", int'(cr_data), 512);
    chk("R11", "y_stb", int'(y_stb), 0);
    chk("R11", "c_stb", int'(c_stb), 0);
    sample("R11", 5, 0, 3, 0, 1'b0);
  endtask

  task automatic t_ext();
    run_line("R3", 0, 10, 1'b0);
    sample("R3", 0, 11, 0, 0, 1'b0);
    chk("R3", "start", int'(y_data), 20);
    for (int h = 1; h < 720; h++) sample("R3", h, 11, 0, 0, 1'b0);
    chk("R3", "end", int'(y_data), 984);
  endtask

  task automatic t_limit();
    run_line("R4", 1, 20, 1'b0);
    sample("R4", 0, 21, 1, 1, 1'b0);
    chk("R4", "start", int'(y_data), 4);
    for (int h = 1; h < 720; h++) sample("R4", h, 21, 1, 1, 1'b0);
    chk("R4", "end", int'(y_data), 1016);
  endtask

  task automatic t_shallow(); run_line("R5", 2, 30, 1'b0); endtask
  task automatic t_gray();    run_line("R6", 3, 485, 1'b0); endtask

  task automatic t_cosite();
    for (int h = 0; h < 360; h++) sample("R7", h, 40, 4, 4, 1'b0);
    sample("R7", 360, 40, 4, 4, 1'b0);
    chk("R7", "pulse y", int'(y_data), 940);
    chk("R7", "pulse cb", int'(cb_data), 960);
    chk("R7", "pulse cr", int'(cr_data), 960);
    sample("R7", 361, 40, 4, 4, 1'b0);
    chk("R7", "after y", int'(y_data), 64);
    chk("R7", "held cb", int'(cb_data), 960);
    for (int h = 362; h < H_TOTAL; h++) sample("R7", h, 40, 4, 4, 1'b0);
  endtask

  task automatic t_other();
    for (int p = 5; p < 8; p++) run_line("R8", p, 50, 1'b0);
  endtask

  task automatic t_blank();
    for (int h = 0; h < 720; h += 7) sample("R2", h, 486, 3, 3, 1'b0);
    for (int h = 0; h < 720; h += 11) sample("R2", h, 500, 0, 0, 1'b0);
    sample("R2", 0, 60, 3, 3, 1'b0);
    for (int h = 1; h < 722; h++) sample("R2", h, 60, 3, 3, 1'b0);
    chk("R2", "first blank y", int'(y_data), 64);
  endtask

  task automatic t_latch();
    sample("R9", 0, 70, 0, 0, 1'b0);
    for (int h = 1; h < 10; h++) sample("R9", h, 70, 3, 0, 1'b0);
    sample("R9", 0, 71, 3, 3, 1'b0);
    chk("R9", "switch", int'(y_data), 508);
    step(0, 71, 4, 1'b0, 1'b0);
    chk("R9", "idle y_stb", int'(y_stb), 0);
    chk("R9", "idle c_stb", int'(c_stb), 0);
    chk("R1", "idle hold y", int'(y_data), 508);
    for (int h = 1; h < 400; h++) sample("R9", h, 71, 4, 3, 1'b0);
  endtask

  task automatic t_8bit();
    run_line("R10", 1, 80, 1'b1);
    run_line("R10", 4, 81, 1'b1);
    sample("R10", 0, 82, 0, 0, 1'b1);
    chk("R10", "ramp start", int'(y_data), 20);
    sample("R10", 1, 82, 0, 0, 1'b1);
    chk("R10", "ramp low bits", int'(y_data), 20);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ext();
    t_limit();
    t_shallow();
    t_gray();
    t_cosite();
    t_other();
    t_blank();
    t_latch();
    t_8bit();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule